// File: doc/BRIEF.md
# Sixteen-Line Interrupt Expander

This block gathers sixteen external interrupt sources into a single active-high, level-sensitive request line towards a host processor, in the manner of a small board-level logic device. Each source line is captured into its own sticky status bit. A per-line enable mask decides which pending bits can drive the request. The request stays high for as long as any bit is both pending and enabled.

The host reaches the block through a synchronous 16-bit register port with chip-select, write-enable, byte offset, write data and registered read data. The mask is never updated by read-modify-write. One location sets enable bits for every 1 written, and another clears enable bits for every 1 written. Pending bits are acknowledged by writing ones to the status location. A separate location returns the raw, unlatched input levels.

At start-up the host writes all ones to the mask-clear location and then to the status location. Lines 8 (network controller) and 10 and 11 (two serial channels) are typical users.

Top module: `irq_expander`

## Requirements
- R1: After reset the status bits and the enable bits are all 0, irq_o is 0 and rdata_o is 0.
- R2: A source input that is 1 at a rising clock edge sets its status bit at that edge. The bit stays set after the input returns to 0. A read of offset 0x16 returns the status bits, with bit n belonging to line n.
- R3: A write to offset 0x16 clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R4: If a status bit is cleared by a write in the same cycle as its source input is 1, the bit stays set.
- R5: A read of offset 0x18 returns the live source input levels sampled at the request edge, without latching.
- R6: A write to offset 0x1A sets each enable bit written as 1 and leaves the others unchanged. Reads of 0x1A and of 0x1C return the enable mask.
- R7: A write to offset 0x1C clears each enable bit written as 1 and leaves the others unchanged.
- R8: irq_o is a register. At each edge it takes the OR over all lines of (status AND enable) as held before that edge, so it follows a status or mask change one clock later. Status bits of disabled lines still latch.
- R9: The read data is registered. After a read request edge it holds the addressed value for one cycle. It is 0 after edges with no read and for reads of any offset other than 0x16, 0x18, 0x1A and 0x1C. Writes to 0x18 or to unmapped offsets change neither status nor mask.
- R10: Writing 0xFFFF to 0x1C and then 0xFFFF to 0x16 leaves all enable and status bits at 0 and irq_o at 0, after which a line enabled again raises irq_o normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_src_i | input | 16 | Interrupt source levels, bit n is line n |
| cs_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid the cycle after a read request |
| irq_o | output | 1 | Level-sensitive request to the host, active high |

## Verification
A source level or a register write takes effect in status or mask at the edge where it is presented. irq_o follows at the next edge, and read data appears right after the request edge. The bench drives inputs on falling edges and samples on falling edges. A read is therefore checked at the first falling edge after its request edge. irq_o is checked once at the falling edge right after the updating edge, where it must still show the old level, and again one clock later, where it must show the new level. The same-cycle clear-and-assert collision is presented in a single cycle, and the result is read back through offset 0x16.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
  localparam int unsigned LINES_DEF = 16;
  localparam int unsigned ADDR_W_DEF = 8;

  localparam logic [ADDR_W_DEF-1:0] OFS_STATUS = 8'h16;
  localparam logic [ADDR_W_DEF-1:0] OFS_LIVE   = 8'h18;
  localparam logic [ADDR_W_DEF-1:0] OFS_EN_SET = 8'h1A;
  localparam logic [ADDR_W_DEF-1:0] OFS_EN_CLR = 8'h1C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_LIVE,
    SEL_EN_SET,
    SEL_EN_CLR
  } reg_sel_e;
endpackage

// File: rtl/irqx_status.sv
module irqx_status #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic         ack_en_i,
  input  logic [N-1:0] ack_bits_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] status_q;

  for (genvar i = 0; i < N; i++) begin : g_line
    // a new event outranks a same-cycle acknowledge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) status_q[i] <= 1'b0;
      else if (src_i[i]) status_q[i] <= 1'b1;
      else if (ack_en_i && ack_bits_i[i]) status_q[i] <= 1'b0;
    end
  end

  assign status_o = status_q;

  a_r2_event_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(src_i)) == $past(src_i)));

  a_r3_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_en_i |=> ((status_q & $past(ack_bits_i & ~src_i)) == '0));

  a_r3_zero_bits_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(status_q & ~(ack_bits_i & {N{ack_en_i}}))) ==
              $past(status_q & ~(ack_bits_i & {N{ack_en_i}}))));
endmodule

// File: rtl/irqx_mask.sv
module irqx_mask #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_en_i,
  input  logic         clr_en_i,
  input  logic [N-1:0] bits_i,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else if (set_en_i) mask_q <= mask_q | bits_i;
    else if (clr_en_i) mask_q <= mask_q & ~bits_i;
  end

  assign mask_o = mask_q;

  a_r6_set_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |=> ((mask_q & $past(bits_i | mask_q)) == $past(bits_i | mask_q)));

  a_r7_clr_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && !set_en_i) |=> (mask_q == ($past(mask_q) & ~$past(bits_i))));

  a_r9_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_en_i && !clr_en_i) |=> $stable(mask_q));
endmodule

// File: rtl/irqx_regbus.sv
module irqx_regbus
  import irqx_pkg::*;
#(
  parameter int unsigned N      = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  input  logic [N-1:0]      status_i,
  input  logic [N-1:0]      live_i,
  input  logic [N-1:0]      mask_i,
  output logic              ack_en_o,
  output logic              en_set_o,
  output logic              en_clr_o,
  output logic [N-1:0]      rdata_o
);
  reg_sel_e     sel;
  logic [N-1:0] rd_mux;
  logic [N-1:0] rdata_q;

  always_comb begin
    sel = SEL_NONE;
    if (addr_i == ADDR_W'(OFS_STATUS))      sel = SEL_STATUS;
    else if (addr_i == ADDR_W'(OFS_LIVE))   sel = SEL_LIVE;
    else if (addr_i == ADDR_W'(OFS_EN_SET)) sel = SEL_EN_SET;
    else if (addr_i == ADDR_W'(OFS_EN_CLR)) sel = SEL_EN_CLR;
  end

  assign ack_en_o = cs_i && we_i && (sel == SEL_STATUS);
  assign en_set_o = cs_i && we_i && (sel == SEL_EN_SET);
  assign en_clr_o = cs_i && we_i && (sel == SEL_EN_CLR);

  always_comb begin
    unique case (sel)
      SEL_STATUS:            rd_mux = status_i;
      SEL_LIVE:              rd_mux = live_i;
      SEL_EN_SET, SEL_EN_CLR: rd_mux = mask_i;
      default:               rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (cs_i && !we_i) rdata_q <= rd_mux;
    else rdata_q <= '0;
  end

  assign rdata_o = rdata_q;

  a_r9_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && !we_i) |=> (rdata_q == '0));

  a_r9_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && !we_i && (addr_i != ADDR_W'(OFS_STATUS)) && (addr_i != ADDR_W'(OFS_LIVE)) &&
     (addr_i != ADDR_W'(OFS_EN_SET)) && (addr_i != ADDR_W'(OFS_EN_CLR)))
    |=> (rdata_q == '0));

  a_r5_live_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && !we_i && (addr_i == ADDR_W'(OFS_LIVE))) |=> (rdata_q == $past(live_i)));

  a_r9_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ack_en_o, en_set_o, en_clr_o}));
endmodule

// File: rtl/irqx_aggr.sv
module irqx_aggr #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] status_i,
  input  logic [N-1:0] mask_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else irq_q <= |(status_i & mask_i);
  end

  assign irq_o = irq_q;

  a_r8_level_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_q == ($countones($past(status_i & mask_i)) != 0)));

  a_r8_no_mask_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |=> !irq_q);
endmodule

// File: rtl/irq_expander.sv
module irq_expander
  import irqx_pkg::*;
#(
  parameter int unsigned NUM_LINES = LINES_DEF,
  parameter int unsigned ADDR_W    = ADDR_W_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_src_i,
  input  logic                 cs_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_LINES-1:0] wdata_i,
  output logic [NUM_LINES-1:0] rdata_o,
  output logic                 irq_o
);
  logic [NUM_LINES-1:0] status;
  logic [NUM_LINES-1:0] mask;
  logic                 ack_en;
  logic                 en_set;
  logic                 en_clr;

  irqx_regbus #(.N(NUM_LINES), .ADDR_W(ADDR_W)) u_regbus (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_i     (cs_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .status_i (status),
    .live_i   (irq_src_i),
    .mask_i   (mask),
    .ack_en_o (ack_en),
    .en_set_o (en_set),
    .en_clr_o (en_clr),
    .rdata_o  (rdata_o)
  );

  irqx_status #(.N(NUM_LINES)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (irq_src_i),
    .ack_en_i   (ack_en),
    .ack_bits_i (wdata_i),
    .status_o   (status)
  );

  irqx_mask #(.N(NUM_LINES)) u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_en_i (en_set),
    .clr_en_i (en_clr),
    .bits_i   (wdata_i),
    .mask_o   (mask)
  );

  irqx_aggr #(.N(NUM_LINES)) u_aggr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (status),
    .mask_i   (mask),
    .irq_o    (irq_o)
  );

  a_r1_reset_quiet: assert property (@(posedge clk_i) $rose(rst_ni) |-> !irq_o);
endmodule

// File: tb/tb_irq_expander.sv
module tb_irq_expander;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] irq_src_i = '0;
  logic        cs_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  irq_expander dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_src_i(irq_src_i), .cs_i(cs_i),
    .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    cs_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    tick();
    cs_i = 1'b0; we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    cs_i = 1'b1; we_i = 1'b0; addr_i = a;
    tick();
    d = rdata_o;
    cs_i = 1'b0;
  endtask

  task automatic clean();
    wr(8'h1C, 16'hFFFF);
    wr(8'h16, 16'hFFFF);
    tick();
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 irq", {15'd0, irq_o}, 16'h0);
    check("R1 rdata", rdata_o, 16'h0);
    rd(8'h16, v); check("R1 status", v, 16'h0);
    rd(8'h1A, v); check("R1 mask", v, 16'h0);
  endtask

  task automatic t_latch();
    logic [15:0] v;
    clean();
    irq_src_i = 16'h0100; tick(); irq_src_i = '0;
    tick();
    rd(8'h16, v); check("R2 sticky status", v, 16'h0100);
    check("R8 masked line no irq", {15'd0, irq_o}, 16'h0);
  endtask

  task automatic t_live();
    logic [15:0] v;
    clean();
    irq_src_i = 16'h0C05;
    rd(8'h18, v); check("R5 live read", v, 16'h0C05);
    irq_src_i = '0;
    rd(8'h18, v); check("R5 live after drop", v, 16'h0000);
    rd(8'h16, v); check("R2 status from live", v, 16'h0C05);
  endtask

  task automatic t_ack();
    logic [15:0] v;
    // status 0x0C05 from previous test
    wr(8'h16, 16'h0005);
    rd(8'h16, v); check("R3 partial ack", v, 16'h0C00);
    wr(8'h16, 16'h0000);
    rd(8'h16, v); check("R3 zero write keeps", v, 16'h0C00);
  endtask

  task automatic t_mask();
    logic [15:0] v;
    clean();
    irq_src_i = 16'h0100; tick(); irq_src_i = '0;
    wr(8'h1A, 16'h0100);
    check("R8 irq one clock late", {15'd0, irq_o}, 16'h0);
    tick();
    check("R8 irq raised", {15'd0, irq_o}, 16'h1);
    wr(8'h1A, 16'h0800);
    rd(8'h1A, v); check("R6 set accumulates", v, 16'h0900);
    rd(8'h1C, v); check("R6 read at clear offset", v, 16'h0900);
    wr(8'h1C, 16'h0100);
    check("R8 irq still high one clock", {15'd0, irq_o}, 16'h1);
    tick();
    check("R7 irq low after disable", {15'd0, irq_o}, 16'h0);
    rd(8'h1A, v); check("R7 partial clear", v, 16'h0800);
  endtask

  task automatic t_collision();
    logic [15:0] v;
    clean();
    wr(8'h1A, 16'h0400);
    irq_src_i = 16'h0400;
    wr(8'h16, 16'h0400);
    irq_src_i = '0;
    rd(8'h16, v); check("R4 assert wins over ack", v, 16'h0400);
    check("R4 irq held", {15'd0, irq_o}, 16'h1);
    wr(8'h16, 16'h0400);
    tick();
    check("R3 ack drops irq", {15'd0, irq_o}, 16'h0);
  endtask

  task automatic t_unmapped();
    logic [15:0] v;
    clean();
    irq_src_i = 16'h0002; tick(); irq_src_i = '0;
    wr(8'h1A, 16'h0002);
    rd(8'h00, v); check("R9 unmapped 0x00", v, 16'h0);
    rd(8'h17, v); check("R9 unmapped 0x17", v, 16'h0);
    rd(8'h1E, v); check("R9 unmapped 0x1E", v, 16'h0);
    tick();
    check("R9 idle rdata", rdata_o, 16'h0);
    wr(8'h18, 16'hFFFF);
    wr(8'h20, 16'hFFFF);
    rd(8'h16, v); check("R9 status untouched", v, 16'h0002);
    rd(8'h1A, v); check("R9 mask untouched", v, 16'h0002);
  endtask

  task automatic t_init();
    logic [15:0] v;
    wr(8'h1A, 16'hFFFF);
    irq_src_i = 16'h0D00; tick(); irq_src_i = '0;
    tick();
    check("R10 pre irq", {15'd0, irq_o}, 16'h1);
    wr(8'h1C, 16'hFFFF);
    wr(8'h16, 16'hFFFF);
    tick();
    check("R10 irq low", {15'd0, irq_o}, 16'h0);
    rd(8'h16, v); check("R10 status zero", v, 16'h0);
    rd(8'h1A, v); check("R10 mask zero", v, 16'h0);
    wr(8'h1A, 16'h0100);
    irq_src_i = 16'h0100; tick(); irq_src_i = '0;
    tick();
    check("R10 line 8 works again", {15'd0, irq_o}, 16'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_latch();
    t_live();
    t_ack();
    t_mask();
    t_collision();
    t_unmapped();
    t_init();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule